// File: doc/BRIEF.md
# Shared Memory Window Bus Bridge

This bridge sits between a host processor bus and a window onto a memory that several internal clients share. Every host access has to win arbitration at the memory controller before it runs, so how long it takes depends on load. The bridge turns host accesses into requests on a req/gnt/done memory port.

Reads and writes complete in different ways. A read holds the bus: the bridge keeps its ready output low until the memory read has finished, then returns the data and pulses ready. Because of this, a DMA engine can read through the window. A write does not hold the bus. It is parked in one holding register and acknowledged at once. A live readiness flag then reads zero until the memory commits the write. Software must poll the flag before it issues the next write, which is why DMA writes into the window are not supported.

Writes can be 8, 16 or 32 bits wide, with byte enables taken from the low address bits. A parameter selects the read variant: one accepts reads of any width, the other accepts only 32-bit reads. Misaligned accesses, accesses of the reserved size and writes issued while the flag is low are not forwarded. Each of these raises a sticky error bit.

Top module: `mwin_bridge`

## Requirements
- R1: After reset, host_ready is 0, wr_free is 1, err_overrun and err_access are 0, and mem_req is 0.
- R2: A legal read is a one-cycle host_sel pulse with host_wr=0. host_ready stays 0 for at least the cycle after the pulse and until the memory port signals done. host_ready then goes high for exactly one cycle, with host_rdata valid in that cycle.
- R3: A legal write pulse gets host_ready=1 in the next cycle, and wr_free reads 0 from that same cycle. wr_free returns to 1 in the cycle after the memory port's done for that write. It is never set sticky.
- R4: A legal write that arrives while wr_free is 0 is dropped and still gets host_ready. It sets err_overrun, which stays set until err_clr. The pending write reaches memory unchanged, and no second memory write takes place.
- R5: host_size encodes the access width: 0 = byte, 1 = halfword, 2 = word, 3 = reserved. Let k = host_addr[1:0]. A forwarded write has mem_be equal to 1<<k for a byte, 3<<k for a halfword and 4'b1111 for a word. mem_wdata is host_wdata shifted left by 8*k, and mem_addr is host_addr>>2. A read always uses mem_be = 4'b1111.
- R6: These accesses raise err_access: a halfword with k odd, a word with k not 0, and any access of size 3. They get host_ready in the next cycle, return host_rdata = 0, and produce no memory request.
- R7: In the any-width variant, read data is the memory word shifted right by 8*k and zero-extended, keeping 8 bits for a byte and 16 bits for a halfword.
- R8: In the word-only variant, a byte or halfword read completes with host_ready in the next cycle and host_rdata = 0. It sets err_access and is not forwarded.
- R9: mem_req stays high until mem_gnt, and mem_addr, mem_be, mem_wdata and mem_we stay stable while it waits.
- R10: A read issued while a write is still pending runs after that write has committed, so it returns the newly written data.
- R11: err_clr clears both sticky error bits in the next cycle. An error event in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | One-cycle access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | Access width code (R5) |
| host_addr | input | ADDR_W | Byte address within the window |
| host_wdata | input | 32 | Write data, right-aligned |
| host_rdata | output | 32 | Read data, right-aligned |
| host_ready | output | 1 | Access completion pulse |
| wr_free | output | 1 | Live flag: holding register empty |
| err_overrun | output | 1 | Sticky: write dropped while busy |
| err_access | output | 1 | Sticky: misaligned or unsupported access |
| err_clr | input | 1 | Clears both sticky error bits |
| mem_req | output | 1 | Memory request, held until grant |
| mem_we | output | 1 | Memory operation is a write |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data, lane-placed |
| mem_gnt | input | 1 | Arbiter grant |
| mem_done | input | 1 | Memory operation finished |
| mem_rdata | input | 32 | Memory read data, valid with done |

## Verification
On every cycle, the assertions check the following: the request is held stable until it is granted, the readiness flag falls only after a write strobe and rises only after a committed memory write, and a write issued while busy is flagged. They also check that byte-enable patterns are always legal, that reserved-size accesses return zero with an error, and that narrow reads in the word-only variant are refused. Only the bench scenarios, run against a randomly delayed arbiter, can show the rest. That covers the correct placement of lanes and data for every size and offset, the zero-extended read extraction, the ordering of a read behind a pending write, and the fact that a dropped write leaves the committed data unchanged.

// File: rtl/mwin_pkg.sv
// Shared types and widths for the memory window bridge.
// Assumes a 32-bit host data path split into byte lanes.
package mwin_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             legal;
        logic [LANES-1:0] be;
    } lane_sel_t;
endpackage

// File: rtl/mwin_lane_decode.sv
// Decodes access width and byte offset into a lane mask and an alignment
// verdict, and places right-aligned write data onto its lanes.
// Assumes natural alignment is required for every width.
module mwin_lane_decode
    import mwin_pkg::*;
(
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] data_in,
    output lane_sel_t         sel,
    output logic [DATA_W-1:0] data_lane
);
    logic [OFF_W:0]   span;
    logic             legal;
    logic [LANES-1:0] be_raw;

    // Number of lanes covered by the access width.
    always_comb begin
        unique case (size)
            SZ_BYTE: span = (OFF_W+1)'(1);
            SZ_HALF: span = (OFF_W+1)'(2);
            SZ_WORD: span = (OFF_W+1)'(LANES);
            default: span = '0;
        endcase
    end

    // An access is legal when its width is defined and the offset is a multiple of it.
    assign legal = (span != '0) && ((off & OFF_W'(span - 1'b1)) == '0);

    // One enable per lane: set when the lane falls inside [off, off+span).
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W:0] LI = (OFF_W+1)'(i);
        assign be_raw[i] = (LI >= {1'b0, off}) && (LI < ({1'b0, off} + span));
    end

    assign sel.legal = legal;
    assign sel.be    = be_raw & {LANES{legal}};
    assign data_lane = data_in << {off, 3'b000};
endmodule

// File: rtl/mwin_read_align.sv
// Extracts a right-aligned, zero-extended value of the requested width from a
// memory word. Assumes the offset was already checked for alignment.
module mwin_read_align
    import mwin_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] mask;

    // Shift the addressed lane down to bit 0.
    assign shifted = word >> {off, 3'b000};

    // Keep only the bits of the access width.
    always_comb begin
        unique case (size)
            SZ_BYTE: mask = {{(DATA_W-8){1'b0}}, 8'hFF};
            SZ_HALF: mask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: mask = '1;
        endcase
    end

    assign data_out = shifted & mask;
endmodule

// File: rtl/mwin_post_buf.sv
// Single holding register for a posted write. Loaded by the host side,
// emptied when the memory side reports the write committed.
// Assumes load is only asserted while the register is empty.
module mwin_post_buf
    import mwin_pkg::*;
#(
    parameter int WADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [WADDR_W-1:0] load_addr,
    input  logic [LANES-1:0]   load_be,
    input  logic [DATA_W-1:0]  load_data,
    input  logic               commit,
    output logic               valid,
    output logic [WADDR_W-1:0] addr,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  data
);
    // Occupancy: set on load, cleared on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid <= 1'b0;
        else if (load)   valid <= 1'b1;
        else if (commit) valid <= 1'b0;
    end

    // Contents captured only on load and held until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            be   <= '0;
            data <= '0;
        end else if (load) begin
            addr <= load_addr;
            be   <= load_be;
            data <= load_data;
        end
    end
endmodule

// File: rtl/mwin_mem_seq.sv
// Memory port sequencer: raises a request, holds it until grant, then waits
// for done and reports completion. Assumes done never comes before grant.
module mwin_mem_seq
    import mwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_we,
    input  logic gnt,
    input  logic done,
    output logic req,
    output logic busy,
    output logic op_we,
    output logic fin
);
    seq_state_e state;

    // Request / wait state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            unique case (state)
                SQ_IDLE: if (start) state <= SQ_REQ;
                SQ_REQ:  if (gnt)   state <= SQ_WAIT;
                SQ_WAIT: if (done)  state <= SQ_IDLE;
                default:            state <= SQ_IDLE;
            endcase
        end
    end

    // Direction of the operation in flight, latched on start.
    always_ff @(posedge clk) begin
        if (!rst_n)                          op_we <= 1'b0;
        else if (state == SQ_IDLE && start)  op_we <= start_we;
    end

    assign req  = (state == SQ_REQ);
    assign busy = (state != SQ_IDLE);
    assign fin  = (state == SQ_WAIT) && done;
endmodule

// File: rtl/mwin_bridge.sv
// Host-to-shared-memory window bridge. Reads stall the host until the memory
// read returns; writes are posted into one holding register tracked by a live
// readiness flag. Assumes the host issues one-cycle strobes and waits for
// host_ready before the next read.
module mwin_bridge
    import mwin_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter bit READ_ANY = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_sel,
    input  logic                      host_wr,
    input  logic [1:0]                host_size,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [DATA_W-1:0]         host_wdata,
    output logic [DATA_W-1:0]         host_rdata,
    output logic                      host_ready,
    output logic                      wr_free,
    output logic                      err_overrun,
    output logic                      err_access,
    input  logic                      err_clr,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-OFF_W-1:0]   mem_addr,
    output logic [LANES-1:0]          mem_be,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic                      mem_gnt,
    input  logic                      mem_done,
    input  logic [DATA_W-1:0]         mem_rdata
);
    localparam int WADDR_W = ADDR_W - OFF_W;

    acc_size_e          h_size;
    logic [OFF_W-1:0]   h_off;
    logic [WADDR_W-1:0] h_waddr;
    lane_sel_t          dec;
    logic [DATA_W-1:0]  lane_wdata;

    logic wr_strobe, rd_strobe, rd_size_ok;
    logic wr_accept, wr_overrun, rd_accept, acc_bad;

    logic               wp_valid;
    logic [WADDR_W-1:0] wp_addr;
    logic [LANES-1:0]   wp_be;
    logic [DATA_W-1:0]  wp_data;

    logic               rd_pend;
    logic [WADDR_W-1:0] rd_waddr;
    acc_size_e          rd_size;
    logic [OFF_W-1:0]   rd_off;

    logic seq_start, seq_busy, seq_we, seq_fin, seq_req;
    logic wr_commit, rd_fin;
    logic [DATA_W-1:0] rd_aligned;

    assign h_size  = acc_size_e'(host_size);
    assign h_off   = host_addr[OFF_W-1:0];
    assign h_waddr = host_addr[ADDR_W-1:OFF_W];

    mwin_lane_decode u_dec (
        .size      (h_size),
        .off       (h_off),
        .data_in   (host_wdata),
        .sel       (dec),
        .data_lane (lane_wdata)
    );

    // Read width policy chosen by the variant parameter.
    if (READ_ANY) begin : g_rd_any
        assign rd_size_ok = 1'b1;
    end else begin : g_rd_word
        assign rd_size_ok = (h_size == SZ_WORD);
    end

    // Classification of the current host strobe.
    assign wr_strobe  = host_sel &  host_wr;
    assign rd_strobe  = host_sel & ~host_wr;
    assign wr_accept  = wr_strobe & dec.legal & ~wp_valid;
    assign wr_overrun = wr_strobe & dec.legal &  wp_valid;
    assign rd_accept  = rd_strobe & dec.legal & rd_size_ok & ~rd_pend;
    assign acc_bad    = host_sel & ~(dec.legal & (host_wr | rd_size_ok));

    mwin_post_buf #(.WADDR_W(WADDR_W)) u_post (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_accept),
        .load_addr (h_waddr),
        .load_be   (dec.be),
        .load_data (lane_wdata),
        .commit    (wr_commit),
        .valid     (wp_valid),
        .addr      (wp_addr),
        .be        (wp_be),
        .data      (wp_data)
    );

    // Pending read: set on an accepted read, cleared when its data returns.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_pend <= 1'b0;
        else if (rd_accept) rd_pend <= 1'b1;
        else if (rd_fin)    rd_pend <= 1'b0;
    end

    // Address and shape of the pending read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_waddr <= '0;
            rd_size  <= SZ_WORD;
            rd_off   <= '0;
        end else if (rd_accept) begin
            rd_waddr <= h_waddr;
            rd_size  <= h_size;
            rd_off   <= h_off;
        end
    end

    // Posted write goes first so a later read sees its data.
    assign seq_start = ~seq_busy & (wp_valid | rd_pend);

    mwin_mem_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start),
        .start_we (wp_valid),
        .gnt      (mem_gnt),
        .done     (mem_done),
        .req      (seq_req),
        .busy     (seq_busy),
        .op_we    (seq_we),
        .fin      (seq_fin)
    );

    assign wr_commit = seq_fin &  seq_we;
    assign rd_fin    = seq_fin & ~seq_we;

    mwin_read_align u_align (
        .word     (mem_rdata),
        .size     (rd_size),
        .off      (rd_off),
        .data_out (rd_aligned)
    );

    // Host completion pulse: immediate for everything except an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) host_ready <= 1'b0;
        else        host_ready <= (host_sel & ~rd_accept) | rd_fin;
    end

    // Read data: memory result on read completion, zero for refused accesses.
    always_ff @(posedge clk) begin
        if (!rst_n)        host_rdata <= '0;
        else if (rd_fin)   host_rdata <= rd_aligned;
        else if (host_sel) host_rdata <= '0;
    end

    // Sticky error bits: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_overrun <= 1'b0;
            err_access  <= 1'b0;
        end else begin
            err_overrun <= (err_overrun & ~err_clr) | wr_overrun;
            err_access  <= (err_access  & ~err_clr) | acc_bad;
        end
    end

    assign wr_free   = ~wp_valid;
    assign mem_req   = seq_req;
    assign mem_we    = seq_busy & seq_we;
    assign mem_addr  = seq_we ? wp_addr : rd_waddr;
    assign mem_be    = seq_we ? wp_be   : {LANES{1'b1}};
    assign mem_wdata = wp_data;
endmodule

// File: rtl/mwin_bridge_chk.sv
// Protocol checker for mwin_bridge, bound to every instance of it.
// Observes ports only.
module mwin_bridge_chk
    import mwin_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter bit READ_ANY = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    host_sel,
    input logic                    host_wr,
    input logic [1:0]              host_size,
    input logic [DATA_W-1:0]       host_rdata,
    input logic                    host_ready,
    input logic                    wr_free,
    input logic                    err_overrun,
    input logic                    err_access,
    input logic                    err_clr,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [ADDR_W-OFF_W-1:0] mem_addr,
    input logic [LANES-1:0]        mem_be,
    input logic [DATA_W-1:0]       mem_wdata,
    input logic                    mem_gnt,
    input logic                    mem_done
);
    // R9: request held with stable payload until granted
    p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_wdata) && $stable(mem_we));

    // R3: flag only falls after a host write strobe
    p_flag_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_free) |-> $past(host_sel && host_wr));

    // R3: flag only rises after a memory write completes
    p_flag_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_free) |-> $past(mem_done && mem_we));

    // R4: a write issued while busy is reported
    p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel && host_wr && !wr_free |=> err_overrun || err_access);

    // R11: overrun bit is sticky until cleared
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun && !err_clr |=> err_overrun);

    // R5: write byte enables form a naturally aligned group
    p_wr_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_be == 4'b0001 || mem_be == 4'b0010 ||
            mem_be == 4'b0100 || mem_be == 4'b1000 || mem_be == 4'b0011 ||
            mem_be == 4'b1100 || mem_be == 4'b1111));

    // R5: reads fetch the whole word
    p_rd_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_be == 4'b1111);

    // R6: reserved size completes next cycle with an error
    p_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel && host_size == 2'd3 |=> host_ready && err_access);

    // R6: refused read returns zero
    p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel && !host_wr && host_size == 2'd3 |=> host_rdata == '0);

    if (!READ_ANY) begin : g_word_only
        // R8: narrow read refused in word-only variant
        p_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            host_sel && !host_wr && host_size != 2'd2
            |=> host_ready && host_rdata == '0 && err_access);
    end
endmodule

bind mwin_bridge mwin_bridge_chk #(.ADDR_W(ADDR_W), .READ_ANY(READ_ANY)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_sel    (host_sel),
    .host_wr     (host_wr),
    .host_size   (host_size),
    .host_rdata  (host_rdata),
    .host_ready  (host_ready),
    .wr_free     (wr_free),
    .err_overrun (err_overrun),
    .err_access  (err_access),
    .err_clr     (err_clr),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .mem_gnt     (mem_gnt),
    .mem_done    (mem_done)
);

// File: tb/mwin_bridge_tb_top.sv
`timescale 1ns/1ps

// Random-latency arbiter and memory model standing in for the shared memory.
module mwin_mem_stub #(parameter int MAW = 4) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mem_req,
    input  logic            mem_we,
    input  logic [MAW-1:0]  mem_addr,
    input  logic [3:0]      mem_be,
    input  logic [31:0]     mem_wdata,
    output logic            gnt,
    output logic            done,
    output logic [31:0]     rdata
);
    logic [31:0]    mem [2**MAW];
    int             st, dly;
    int             g_cnt, hold_bad;
    logic           g_we;
    logic [MAW-1:0] g_addr;
    logic [3:0]     g_be;
    logic [31:0]    g_wdata;
    logic           p_req, p_gnt, p_we;
    logic [MAW-1:0] p_addr;
    logic [3:0]     p_be;
    logic [31:0]    p_wdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            st = 0; dly = $urandom % 4; g_cnt = 0; hold_bad = 0;
            gnt <= 1'b0; done <= 1'b0; rdata <= '0;
            for (int i = 0; i < 2**MAW; i++) mem[i] = '0;
            p_req = 1'b0; p_gnt = 1'b0;
        end else begin
            if (mem_req && p_req && !p_gnt &&
                (mem_addr !== p_addr || mem_be !== p_be || mem_wdata !== p_wdata || mem_we !== p_we))
                hold_bad++;
            p_req = mem_req; p_gnt = gnt; p_addr = mem_addr; p_be = mem_be;
            p_wdata = mem_wdata; p_we = mem_we;
            case (st)
                0: if (mem_req && !gnt) begin
                       if (dly == 0) begin
                           gnt <= 1'b1; st = 1; g_cnt++;
                           g_we = mem_we; g_addr = mem_addr; g_be = mem_be; g_wdata = mem_wdata;
                       end else dly--;
                   end
                1: begin gnt <= 1'b0; dly = $urandom % 4; st = 2; end
                2: if (dly == 0) begin
                       done <= 1'b1; st = 3;
                       if (g_we) begin
                           for (int k = 0; k < 4; k++)
                               if (g_be[k]) mem[g_addr][8*k +: 8] = g_wdata[8*k +: 8];
                       end else rdata <= mem[g_addr];
                   end else dly--;
                default: begin done <= 1'b0; dly = $urandom % 4; st = 0; end
            endcase
        end
    end
endmodule

module mwin_bridge_tb_top;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          sel_a = 1'b0, sel_b = 1'b0, h_wr = 1'b0, e_clr = 1'b0;
    logic [1:0]    h_size = '0;
    logic [AW-1:0] h_addr = '0;
    logic [31:0]   h_wdata = '0;

    logic [31:0] rdata_a, rdata_b, wdat_a, wdat_b, mrd_a, mrd_b;
    logic        ready_a, ready_b, free_a, free_b, ovr_a, ovr_b, acc_a, acc_b;
    logic        req_a, req_b, we_a, we_b, gnt_a, gnt_b, done_a, done_b;
    logic [3:0]  maddr_a, maddr_b, be_a, be_b;

    mwin_bridge #(.ADDR_W(AW), .READ_ANY(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(sel_a), .host_wr(h_wr), .host_size(h_size),
        .host_addr(h_addr), .host_wdata(h_wdata), .host_rdata(rdata_a), .host_ready(ready_a),
        .wr_free(free_a), .err_overrun(ovr_a), .err_access(acc_a), .err_clr(e_clr),
        .mem_req(req_a), .mem_we(we_a), .mem_addr(maddr_a), .mem_be(be_a), .mem_wdata(wdat_a),
        .mem_gnt(gnt_a), .mem_done(done_a), .mem_rdata(mrd_a));

    mwin_mem_stub #(.MAW(AW-2)) stub_a (
        .clk(clk), .rst_n(rst_n), .mem_req(req_a), .mem_we(we_a), .mem_addr(maddr_a),
        .mem_be(be_a), .mem_wdata(wdat_a), .gnt(gnt_a), .done(done_a), .rdata(mrd_a));

    mwin_bridge #(.ADDR_W(AW), .READ_ANY(1'b0)) dut_w (
        .clk(clk), .rst_n(rst_n), .host_sel(sel_b), .host_wr(h_wr), .host_size(h_size),
        .host_addr(h_addr), .host_wdata(h_wdata), .host_rdata(rdata_b), .host_ready(ready_b),
        .wr_free(free_b), .err_overrun(ovr_b), .err_access(acc_b), .err_clr(e_clr),
        .mem_req(req_b), .mem_we(we_b), .mem_addr(maddr_b), .mem_be(be_b), .mem_wdata(wdat_b),
        .mem_gnt(gnt_b), .mem_done(done_b), .mem_rdata(mrd_b));

    mwin_mem_stub #(.MAW(AW-2)) stub_b (
        .clk(clk), .rst_n(rst_n), .mem_req(req_b), .mem_we(we_b), .mem_addr(maddr_b),
        .mem_be(be_b), .mem_wdata(wdat_b), .gnt(gnt_b), .done(done_b), .rdata(mrd_b));

    int          n_cmp = 0, n_bad = 0;
    logic [31:0] shadow [16];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_legal(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'd0: return 1'b1;
            2'd1: return off[0] == 1'b0;
            2'd2: return off == 2'd0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'd0: return 4'b0001 << off;
            2'd1: return 4'b0011 << off;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic strobe(input bit b, input bit wr, input logic [1:0] sz,
                          input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        h_wr = wr; h_size = sz; h_addr = a; h_wdata = d;
        if (b) sel_b = 1'b1; else sel_a = 1'b1;
        @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk); e_clr = 1'b1;
        @(negedge clk); e_clr = 1'b0;
        check("R11 overrun cleared", 32'(ovr_a), 32'd0);
        check("R11 access cleared", 32'(acc_a | acc_b), 32'd0);
    endtask

    task automatic wait_free(input bit b);
        for (int n = 0; n < 200 && !(b ? free_b : free_a); n++) @(negedge clk);
    endtask

    task automatic do_write(input bit b, input logic [1:0] sz, input logic [AW-1:0] a,
                            input logic [31:0] d);
        int c0;
        logic [1:0] off;
        off = a[1:0];
        c0 = b ? stub_b.g_cnt : stub_a.g_cnt;
        strobe(b, 1'b1, sz, a, d);
        check("R3 write ready next cycle", 32'(b ? ready_b : ready_a), 32'd1);
        if (is_legal(sz, off)) begin
            check("R3 flag low after write", 32'(b ? free_b : free_a), 32'd0);
            check("R6 no error on legal write", 32'(b ? acc_b : acc_a), 32'd0);
            wait_free(b);
            check("R3 flag back after commit", 32'(b ? free_b : free_a), 32'd1);
            check("R5 write be", 32'(b ? stub_b.g_be : stub_a.g_be), 32'(exp_be(sz, off)));
            check("R5 write lane data", b ? stub_b.g_wdata : stub_a.g_wdata, d << (8 * off));
            check("R5 write word addr", 32'(b ? stub_b.g_addr : stub_a.g_addr), 32'(a >> 2));
            check("R5 one memory write", (b ? stub_b.g_cnt : stub_a.g_cnt) - c0, 32'd1);
            if (!b)
                for (int k = 0; k < 4; k++)
                    if (exp_be(sz, off)[k]) shadow[a >> 2][8*k +: 8] = (d << (8 * off)) >> (8 * k);
        end else begin
            check("R6 misaligned write error", 32'(b ? acc_b : acc_a), 32'd1);
            check("R6 misaligned write flag", 32'(b ? free_b : free_a), 32'd1);
            repeat (3) @(negedge clk);
            check("R6 misaligned write not forwarded", (b ? stub_b.g_cnt : stub_a.g_cnt) - c0, 32'd0);
            clear_err();
        end
    endtask

    task automatic do_read(input bit b, input logic [1:0] sz, input logic [AW-1:0] a,
                           output logic [31:0] d, output int lat);
        strobe(b, 1'b0, sz, a, 32'h0);
        lat = 0;
        while (!(b ? ready_b : ready_a) && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        d = b ? rdata_b : rdata_a;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d, e, x, y;
        int lat, c0;
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 ready low", 32'(ready_a | ready_b), 32'd0);
        check("R1 flag free", 32'(free_a & free_b), 32'd1);
        check("R1 errors clear", 32'(ovr_a | acc_a | ovr_b | acc_b), 32'd0);
        check("R1 no request", 32'(req_a | req_b), 32'd0);

        // R5/R6/R3: write sweep over every word, offset and size
        for (int w = 0; w < 4; w++)
            for (int o = 0; o < 4; o++)
                for (int s = 0; s < 4; s++)
                    do_write(1'b0, 2'(s), AW'(w * 4 + o),
                             {4'(w), 4'(o), 4'(s), 4'hC, 4'(w ^ o), 4'h7, 4'(s + w), 4'(o + 1)});

        // R7/R2/R6: read sweep, expected values from the shadow image
        for (int w = 0; w < 4; w++)
            for (int o = 0; o < 4; o++)
                for (int s = 0; s < 4; s++) begin
                    do_read(1'b0, 2'(s), AW'(w * 4 + o), d, lat);
                    if (is_legal(2'(s), 2'(o))) begin
                        e = shadow[w] >> (8 * o);
                        if (s == 0) e = e & 32'hFF;
                        else if (s == 1) e = e & 32'hFFFF;
                        check("R7 read data", d, e);
                        check("R2 read stalled at least one cycle", 32'(lat > 0), 32'd1);
                        check("R2 read completed", 32'(lat < 200), 32'd1);
                    end else begin
                        check("R6 refused read immediate", 32'(lat), 32'd0);
                        check("R6 refused read zero", d, 32'd0);
                        check("R6 refused read error", 32'(acc_a), 32'd1);
                        clear_err();
                    end
                end

        // R4: second write while busy is dropped
        x = 32'hDEAD_0001; y = 32'hBEEF_0002;
        c0 = stub_a.g_cnt;
        strobe(1'b0, 1'b1, 2'd2, AW'(0), x);
        strobe(1'b0, 1'b1, 2'd2, AW'(4), y);
        check("R4 dropped write still acked", 32'(ready_a), 32'd1);
        check("R4 overrun raised", 32'(ovr_a), 32'd1);
        wait_free(1'b0);
        repeat (6) @(negedge clk);
        check("R4 pending write intact", stub_a.g_wdata, x);
        check("R4 pending addr intact", 32'(stub_a.g_addr), 32'd0);
        check("R4 only one memory write", stub_a.g_cnt - c0, 32'd1);
        shadow[0] = x;
        do_read(1'b0, 2'd2, AW'(4), d, lat);
        check("R4 dropped target unchanged", d, shadow[1]);
        do_write(1'b0, 2'd2, AW'(12), 32'h1234_5678);
        check("R4 overrun sticky", 32'(ovr_a), 32'd1);
        clear_err();

        // R10: read right behind a posted write returns the new data
        strobe(1'b0, 1'b1, 2'd2, AW'(8), 32'hC0DE_CAFE);
        do_read(1'b0, 2'd2, AW'(8), d, lat);
        check("R10 read after posted write", d, 32'hC0DE_CAFE);
        check("R10 write committed first", 32'(free_a), 32'd1);

        // R8: word-only variant
        do_write(1'b1, 2'd2, AW'(12), 32'hA5A5_3C3C);
        do_read(1'b1, 2'd2, AW'(12), d, lat);
        check("R8 word read allowed", d, 32'hA5A5_3C3C);
        do_read(1'b1, 2'd0, AW'(13), d, lat);
        check("R8 byte read immediate", 32'(lat), 32'd0);
        check("R8 byte read zero", d, 32'd0);
        check("R8 byte read error", 32'(acc_b), 32'd1);
        clear_err();
        do_read(1'b1, 2'd1, AW'(14), d, lat);
        check("R8 half read zero", d, 32'd0);
        check("R8 half read error", 32'(acc_b), 32'd1);

        // R11: error set in same cycle as clear wins
        @(negedge clk);
        h_wr = 1'b0; h_size = 2'd3; sel_b = 1'b1; e_clr = 1'b1;
        @(negedge clk);
        sel_b = 1'b0; e_clr = 1'b0;
        check("R11 set beats clear", 32'(acc_b), 32'd1);
        clear_err();

        // R9: request payload held until grant
        check("R9 request held stable (any-width)", 32'(stub_a.hold_bad), 32'd0);
        check("R9 request held stable (word-only)", 32'(stub_b.hold_bad), 32'd0);
        finish_run();
    end
endmodule